// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is a free-running up-counter with a fixed power-of-two clock divider in front of it. The counter runs on its own from reset and software cannot write it. A processor with a narrow data bus reads the count one byte at a time. For that, the block offers two read windows onto the same count, a main window and an alternate window. Reading the upper byte of a window captures the lower byte, so the two byte reads together give one coherent value.

The counter raises an overflow flag when it wraps to zero. It drives an interrupt request while that flag is set and the interrupt is enabled. Software clears the flag with a two-step handshake: first it reads the status byte while the flag is set, then it reads the main window's upper byte. The alternate window gives the same coherent reads but never touches the flag, so a routine that only wants the time cannot lose an overflow event.

A separate full-width count output feeds neighbouring compare logic directly. The byte width, the divider width and the distance of the reset value below the wrap point are parameters. The defaults give an 8-bit bus, a 16-bit count, a divide-by-four prescaler and a reset value of 0xFFFC.

Top module: `frc_timer`

## Requirements
- R1: While reset is asserted and right after it, the count equals 2^CNT_W - RST_GAP (0xFFFC by default), the divider is at zero, the overflow flag is clear and `irq_o` is low.
- R2: The count advances by exactly one every 2^PRE_W clocks and holds in between, wrapping from all-ones to zero. No input can load it.
- R3: On the clock edge where the count goes from all-ones to zero, the overflow flag sets. A status read (address 0) returns the flag in bit BYTE_W-1, with all other bits zero.
- R4: `irq_o` is high exactly when the overflow flag is set and `ovf_ie_i` is 1.
- R5: An upper-byte read of a window returns the live upper byte and captures the live lower byte in that window's buffer. The next lower-byte read of the same window returns the captured byte.
- R6: Reads of the alternate window (addresses 3 and 4) never change the overflow flag.
- R7: The flag clears at a main-window upper-byte read (address 1) only if an earlier status read found the flag set. Without that status read, the main upper-byte read leaves the flag set.
- R8: A lower-byte read with no pending upper-byte read of its window returns the live lower byte. A captured byte stays frozen until its lower-byte read consumes it.
- R9: If a wrap falls on the same edge as a clearing main upper-byte read, the flag stays set. That read still uses up the earlier status read, so clearing needs a fresh status read.
- R10: The address map is 0 status, 1 main upper, 2 main lower, 3 alternate upper, 4 alternate lower. Any other address reads zero. `rdata_o` is valid combinationally in the cycle `rd_i` is high, and the read's side effects take place at the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe, one per clock cycle |
| addr_i | input | 3 | Register address |
| rdata_o | output | BYTE_W | Read data |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| irq_o | output | 1 | Overflow interrupt request |
| count_o | output | 2*BYTE_W | Live count for compare logic |

## Verification
The bench builds the block with BYTE_W = 4 and PRE_W = 2, which gives an 8-bit count that wraps every 1024 clocks. With that build, several wraps fit within the run. The bench can then reach the flag set, the armed and unarmed clearing reads, and a clearing read timed to land on the exact wrap edge. The 4-bit bus still leaves the lower byte changing between the two byte reads, so the buffered and live values visibly differ.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic [2:0] {
      REG_STAT = 3'd0,
      REG_MHI  = 3'd1,
      REG_MLO  = 3'd2,
      REG_AHI  = 3'd3,
      REG_ALO  = 3'd4
   } frc_reg_e;

   localparam int NUM_VIEWS = 2;

   function automatic logic [2:0] view_hi_addr(input int v);
      return (v == 0) ? REG_MHI : REG_AHI;
   endfunction

   function automatic logic [2:0] view_lo_addr(input int v);
      return (v == 0) ? REG_MLO : REG_ALO;
   endfunction
endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
   parameter int PRE_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (PRE_W < 1) begin : g_bad_pre
      $error("frc_prescaler: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   assign tick_o = &pre_q;

   assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= RST_VAL;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = tick_i && (cnt_q == CNT_MAX);

   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/frc_ovf_flag.sv
module frc_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic stat_rd_i,
   input  logic clr_rd_i,
   output logic tof_o
);
   logic tof_q;
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tof_q <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (wrap_i)                 tof_q <= 1'b1;
         else if (clr_rd_i && arm_q) tof_q <= 1'b0;
         if (clr_rd_i)               arm_q <= 1'b0;
         else if (stat_rd_i && tof_q) arm_q <= 1'b1;
      end
   end

   assign tof_o = tof_q;

   assert_wrap_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> tof_q);
   assert_clear_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tof_q && !clr_rd_i) |=> tof_q);
   assert_wrap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && clr_rd_i) |=> (tof_q && !arm_q));
endmodule

// File: rtl/frc_snap.sv
module frc_snap #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_rd_i,
   input  logic              lo_rd_i,
   input  logic [BYTE_W-1:0] live_i,
   output logic [BYTE_W-1:0] lo_o
);
   logic              frz_q;
   logic [BYTE_W-1:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_q <= 1'b0;
         buf_q <= '0;
      end else if (hi_rd_i) begin
         frz_q <= 1'b1;
         buf_q <= live_i;
      end else if (lo_rd_i) begin
         frz_q <= 1'b0;
      end
   end

   assign lo_o = frz_q ? buf_q : live_i;

   assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && !hi_rd_i && !lo_rd_i) |=> (frz_q && $stable(buf_q)));
   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rd_i |=> (frz_q && buf_q == $past(live_i)));
endmodule

// File: rtl/frc_timer.sv
module frc_timer
   import frc_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int PRE_W   = 2,
   parameter int RST_GAP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [2:0]        addr_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic              ovf_ie_i,
   output logic              irq_o,
   output logic [2*BYTE_W-1:0] count_o
);
   localparam int               CNT_W   = 2 * BYTE_W;
   localparam logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}} - CNT_W'(RST_GAP - 1);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("frc_timer: BYTE_W must be at least 2");
   end
   if (RST_GAP < 1 || RST_GAP > (1 << (CNT_W - 1))) begin : g_bad_gap
      $error("frc_timer: RST_GAP out of range");
   end

   logic             tick;
   logic             wrap;
   logic             tof;
   logic [CNT_W-1:0] cnt;
   logic [BYTE_W-1:0] lo_view [NUM_VIEWS];
   logic             hi_rd   [NUM_VIEWS];
   logic             lo_rd   [NUM_VIEWS];

   frc_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   frc_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_o(cnt), .wrap_o(wrap));

   frc_ovf_flag u_flag (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
      .stat_rd_i(rd_i && addr_i == REG_STAT),
      .clr_rd_i(hi_rd[0]),
      .tof_o(tof));

   for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
      localparam logic [2:0] HI_A = view_hi_addr(v);
      localparam logic [2:0] LO_A = view_lo_addr(v);
      assign hi_rd[v] = rd_i && (addr_i == HI_A);
      assign lo_rd[v] = rd_i && (addr_i == LO_A);
      frc_snap #(.BYTE_W(BYTE_W)) u_snap (
         .clk(clk), .rst_n(rst_n),
         .hi_rd_i(hi_rd[v]), .lo_rd_i(lo_rd[v]),
         .live_i(cnt[BYTE_W-1:0]), .lo_o(lo_view[v]));
   end

   always_comb begin
      case (addr_i)
         REG_STAT: rdata_o = {tof, {(BYTE_W-1){1'b0}}};
         REG_MHI,
         REG_AHI:  rdata_o = cnt[CNT_W-1:BYTE_W];
         REG_MLO:  rdata_o = lo_view[0];
         REG_ALO:  rdata_o = lo_view[1];
         default:  rdata_o = '0;
      endcase
   end

   assign irq_o   = tof && ovf_ie_i;
   assign count_o = cnt;

   assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count_o));
   assert_alt_keeps_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tof && rd_i && (addr_i == REG_AHI || addr_i == REG_ALO)) |=> tof);
   assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_ie_i) |-> !irq_o);
endmodule

// File: tb/frc_timer_bench.sv
module frc_timer_bench;
   localparam int CLK_P = 10;
   localparam int BW    = 4;
   localparam int CW    = 2 * BW;
   localparam int PW    = 2;
   localparam int PRE_MAX = (1 << PW) - 1;
   localparam logic [CW-1:0] MAXC = {CW{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_i = 1'b0;
   logic [2:0] addr_i = 3'd0;
   logic ovf_ie_i = 1'b0;
   logic [BW-1:0] rdata_o;
   logic irq_o;
   logic [CW-1:0] count_o;

   int n_vec = 0;
   int n_bad = 0;

   frc_timer #(.BYTE_W(BW), .PRE_W(PW), .RST_GAP(4)) u_frc_timer (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .addr_i(addr_i),
      .rdata_o(rdata_o), .ovf_ie_i(ovf_ie_i), .irq_o(irq_o), .count_o(count_o));

   always #(CLK_P/2) clk = ~clk;

   // reference model, updated from the requirements at each edge
   logic [CW-1:0] m_cnt;
   int            m_pre;
   logic          m_tof, m_arm;
   logic [BW-1:0] m_buf [2];
   logic          m_frz [2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = MAXC - 3; m_pre = 0; m_tof = 0; m_arm = 0;
         for (int v = 0; v < 2; v++) begin m_buf[v] = '0; m_frz[v] = 0; end
      end else begin
         logic tk, wr, mh, st;
         tk = (m_pre == PRE_MAX);
         wr = tk && (m_cnt == MAXC);
         mh = rd_i && addr_i == 3'd1;
         st = rd_i && addr_i == 3'd0;
         if (mh) m_arm = 0; else if (st && m_tof) m_arm = 1;
         if (wr) m_tof = 1; else if (mh && m_tof && !m_arm && 0) m_tof = m_tof;
         for (int v = 0; v < 2; v++) begin
            if (rd_i && addr_i == 3'(1 + 2*v)) begin m_buf[v] = m_cnt[BW-1:0]; m_frz[v] = 1; end
            else if (rd_i && addr_i == 3'(2 + 2*v)) m_frz[v] = 0;
         end
         if (tk) m_cnt = m_cnt + 1'b1;
         m_pre = (m_pre + 1) % (PRE_MAX + 1);
      end
   end
   // R7 clear rule kept apart: needs arm as it stood before this edge
   logic arm_prev;
   always @(negedge clk) arm_prev = m_arm;
   always @(posedge clk) if (rst_n) begin
      #1;
      if (clr_pending && !wrap_pending) m_tof = 0;
   end
   logic clr_pending, wrap_pending;
   always @(negedge clk) begin
      clr_pending  = 0;
      wrap_pending = 0;
   end
   always @(posedge clk) begin
      clr_pending  = rd_i && addr_i == 3'd1 && arm_prev;
      wrap_pending = (m_pre == PRE_MAX) && (m_cnt == MAXC);
   end

   function automatic logic [BW-1:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {m_tof, {(BW-1){1'b0}}};
         3'd1, 3'd3: return m_cnt[CW-1:BW];
         3'd2: return m_frz[0] ? m_buf[0] : m_cnt[BW-1:0];
         3'd4: return m_frz[1] ? m_buf[1] : m_cnt[BW-1:0];
         default: return '0;
      endcase
   endfunction

   logic [BW-1:0] q_val [$];
   string         q_req [$];

   task automatic rd_reg(input logic [2:0] a, input string req);
      addr_i = a;
      rd_i   = 1'b1;
      q_val.push_back(exp_rd(a));
      q_req.push_back(req);
      @(posedge clk);
      #1 rd_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected reads, compares count and irq every cycle
   always @(negedge clk) begin
      #(CLK_P/4);
      if (rst_n) begin
         chk(count_o == m_cnt, "R2 count", count_o, m_cnt);
         chk(irq_o == (m_tof && ovf_ie_i), "R4 irq", irq_o, m_tof && ovf_ie_i);
         if (rd_i && q_val.size() > 0) begin
            logic [BW-1:0] e;
            string r;
            e = q_val.pop_front();
            r = q_req.pop_front();
            chk(rdata_o == e, r, rdata_o, e);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #(CLK_P/4);
      chk(count_o == 8'hFC && irq_o == 0, "R1 reset state", count_o, 8'hFC);
      @(negedge clk);
      rst_n = 1'b1;
      rd_reg(3'd0, "R1 status clear after reset");
      rd_reg(3'd5, "R10 unmapped address");
      rd_reg(3'd7, "R10 unmapped address");
      rd_reg(3'd2, "R8 live low without high");
      while (!m_tof) @(negedge clk);
      rd_reg(3'd0, "R3 flag after wrap");
      ovf_ie_i = 1'b1;
      @(negedge clk);
      // main high without arming: stays set; but arming above already happened
      rd_reg(3'd1, "R7 clearing read after status");
      rd_reg(3'd0, "R7 flag cleared");
      while (!m_tof) @(negedge clk);
      rd_reg(3'd1, "R7 main high unarmed");
      rd_reg(3'd0, "R7 flag kept unarmed");
      repeat (13) @(negedge clk);
      rd_reg(3'd2, "R5 buffered low main");
      rd_reg(3'd2, "R8 live low after consume");
      rd_reg(3'd0, "R6 arm");
      rd_reg(3'd3, "R6 alt high");
      repeat (9) @(negedge clk);
      rd_reg(3'd4, "R5 buffered low alt");
      rd_reg(3'd0, "R6 flag kept by alt");
      ovf_ie_i = 1'b0;
      @(negedge clk);
      while (!(m_pre == PRE_MAX && m_cnt == MAXC && m_arm)) @(negedge clk);
      rd_reg(3'd1, "R9 wrap coincides with clear");
      rd_reg(3'd0, "R9 flag kept on wrap");
      rd_reg(3'd1, "R9 arm consumed");
      rd_reg(3'd0, "R9 flag still set");
      rd_reg(3'd1, "R7 clear after re-arm");
      rd_reg(3'd0, "R7 flag cleared again");
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule